// File: doc/BRIEF.md
# Write-Permission and Boundary-Protection Gate

This block sits behind the command front-end of a serial nonvolatile memory and decides which write-type instructions may proceed. The front-end hands it one decoded instruction per frame, strobed when chip select falls. With that strobe come the opcode, the 8 received address bits and the levels of the program-enable and register-select pins. The block holds four pieces of state: the write-enable latch, an 8-bit protect boundary, a one-shot "armed" flag for protect-register changes, and a permanent lock flag.

For every accepted programming instruction the block raises a one-cycle commit request for the program-cycle timer, tagged with a kind code and the address. Protect-register updates are applied inside the block in the same cycle. Read-type instructions are granted unconditionally. The boundary value is always available for readback. Retention is modelled as state that persists until the simulation reset.

Top module: `protGate`

## Requirements
- R1: After reset the write-enable latch is clear, the armed flag and the lock flag are clear, the boundary reads 0xFF and counts as cleared, and commitValid and readGrant are low.
- R2: Opcode 1 sets the write-enable latch and opcode 2 clears it, each at its frame strobe. The latch is observed through the acceptance of later writes.
- R3: Opcode 0 (memory read) and opcode 5 (boundary read) raise readGrant for one cycle whatever the latch holds.
- R4: Opcode 3 (word write) is accepted only if the latch is set, program-enable is high and register-select is low. It commits kind 0 with the received address.
- R5: A word write is accepted only when its address is below the boundary, with one exception: when the boundary is 0xFF, address 0xFF is also accepted.
- R6: Opcode 4 (fill all) is accepted only if the boundary is 0xFF, the latch is set, program-enable is high and register-select is low. It commits kind 1.
- R7: Opcode 6 (arm) is accepted only if the latch is set and both program-enable and register-select are high. An accepted arm sets the armed flag and raises no commit.
- R8: Opcodes 7, 8 and 9 need the armed flag. Every frame other than an accepted arm, whether accepted or rejected, clears that flag.
- R9: Opcode 7 loads 0xFF into the boundary and commits kind 2. Opcode 8 loads the address and commits kind 3, but only while the boundary is marked cleared. Opcode 7 sets that mark and an accepted opcode 8 drops it. Both need both pins high.
- R10: Opcode 9 with both pins high sets the lock and commits kind 4. Once locked, opcodes 7, 8 and 9 are always rejected and the boundary never changes again.
- R11: A rejected instruction raises no commit and leaves the latch, boundary, lock and cleared mark unchanged.
- R12: commitValid is high in exactly the cycle after an accepted frame strobe, and never without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle strobe: a decoded frame has ended |
| cmdOp | input | 4 | Decoded opcode (codes listed in R2 to R10) |
| cmdAddr | input | 8 | Address bits received in the frame |
| pgmEn | input | 1 | Program-enable pin level during the frame |
| regSel | input | 1 | Register-select pin level during the frame |
| commitValid | output | 1 | Programming request to the cycle timer |
| commitKind | output | 3 | 0 word, 1 fill, 2 boundary clear, 3 boundary set, 4 lock |
| commitAddr | output | 8 | Address carried with the request |
| readGrant | output | 1 | A read-type frame was granted |
| protValue | output | 8 | Current protect boundary for readback |

## Verification
The bench targets the two address comparisons at the boundary. It writes exactly at the boundary and one below it, and it writes 0xFF with the boundary both at 0xFF and below 0xFF. An off-by-one compare, or a top-address exception left active at all times, would show up as a wrong grant. The armed flag is tested with a read placed between arm and clear, and with an arm that is itself rejected. A design that keeps the flag across frames would then accept a boundary change. After a boundary set, and again after a lock, the bench tries to set or clear the boundary once more. A design missing either guard would let protValue move.

// File: rtl/protGatePkg.sv
package protGatePkg;
  typedef enum logic [3:0] {
    OP_READ   = 4'd0,
    OP_WREN   = 4'd1,
    OP_WRDIS  = 4'd2,
    OP_WORD   = 4'd3,
    OP_FILL   = 4'd4,
    OP_BREAD  = 4'd5,
    OP_ARM    = 4'd6,
    OP_BCLR   = 4'd7,
    OP_BSET   = 4'd8,
    OP_BLOCK  = 4'd9
  } opT;

  typedef enum logic [2:0] {
    CK_WORD = 3'd0,
    CK_FILL = 3'd1,
    CK_BCLR = 3'd2,
    CK_BSET = 3'd3,
    CK_LOCK = 3'd4
  } commitT;

  typedef struct packed {
    logic   weSet;
    logic   weClr;
    logic   armSet;
    logic   armDrop;
    logic   bndOnes;
    logic   bndLoad;
    logic   lockSet;
    logic   commit;
    logic   readOk;
    commitT kind;
  } stbT;
endpackage

// File: rtl/gateCtrl.sv
module gateCtrl
  import protGatePkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              pgmEn,
  input  logic              regSel,
  input  logic              weQ,
  input  logic              armQ,
  input  logic              clrQ,
  input  logic              lockQ,
  input  logic [ADDR_W-1:0] bound,
  output stbT               stb
);
  logic boundOnes;
  logic belowBound;
  logic topAllowed;
  logic memPath;
  logic regPath;
  logic armedPath;

  assign boundOnes  = &bound;
  assign belowBound = cmdAddr < bound;
  assign topAllowed = boundOnes && (&cmdAddr);
  assign memPath    = weQ && pgmEn && !regSel;
  assign regPath    = pgmEn && regSel;
  assign armedPath  = armQ && regPath && !lockQ;

  always_comb begin
    stb = '0;
    stb.kind = CK_WORD;
    if (cmdValid) begin
      unique case (opT'(cmdOp))
        OP_READ, OP_BREAD: stb.readOk = 1'b1;
        OP_WREN:  stb.weSet = 1'b1;
        OP_WRDIS: stb.weClr = 1'b1;
        OP_WORD: begin
          if (memPath && (belowBound || topAllowed)) begin
            stb.commit = 1'b1;
            stb.kind   = CK_WORD;
          end
        end
        OP_FILL: begin
          if (memPath && boundOnes) begin
            stb.commit = 1'b1;
            stb.kind   = CK_FILL;
          end
        end
        OP_ARM: stb.armSet = weQ && regPath;
        OP_BCLR: begin
          if (armedPath) begin
            stb.bndOnes = 1'b1;
            stb.commit  = 1'b1;
            stb.kind    = CK_BCLR;
          end
        end
        OP_BSET: begin
          if (armedPath && clrQ) begin
            stb.bndLoad = 1'b1;
            stb.commit  = 1'b1;
            stb.kind    = CK_BSET;
          end
        end
        OP_BLOCK: begin
          if (armedPath) begin
            stb.lockSet = 1'b1;
            stb.commit  = 1'b1;
            stb.kind    = CK_LOCK;
          end
        end
        default: ;
      endcase
      stb.armDrop = !stb.armSet;
    end
  end
endmodule

// File: rtl/gateRegs.sv
module gateRegs
  import protGatePkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stbT               stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              weQ,
  output logic              armQ,
  output logic              clrQ,
  output logic              lockQ,
  output logic [ADDR_W-1:0] bound,
  output logic              commitValid,
  output logic [2:0]        commitKind,
  output logic [ADDR_W-1:0] commitAddr,
  output logic              readGrant
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ   <= 1'b0;
      armQ  <= 1'b0;
      clrQ  <= 1'b1;
      lockQ <= 1'b0;
      bound <= '1;
    end else begin
      if (stb.weSet) weQ <= 1'b1;
      else if (stb.weClr) weQ <= 1'b0;
      if (stb.armSet) armQ <= 1'b1;
      else if (stb.armDrop) armQ <= 1'b0;
      if (stb.bndOnes) begin
        bound <= '1;
        clrQ  <= 1'b1;
      end else if (stb.bndLoad) begin
        bound <= cmdAddr;
        clrQ  <= 1'b0;
      end
      if (stb.lockSet) lockQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitValid <= 1'b0;
      commitKind  <= '0;
      commitAddr  <= '0;
      readGrant   <= 1'b0;
    end else begin
      commitValid <= stb.commit;
      readGrant   <= stb.readOk;
      if (stb.commit) begin
        commitKind <= stb.kind;
        commitAddr <= cmdAddr;
      end
    end
  end
endmodule

// File: rtl/protGate.sv
module protGate
  import protGatePkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              pgmEn,
  input  logic              regSel,
  output logic              commitValid,
  output logic [2:0]        commitKind,
  output logic [ADDR_W-1:0] commitAddr,
  output logic              readGrant,
  output logic [ADDR_W-1:0] protValue
);
  stbT stb;
  logic weQ;
  logic armQ;
  logic clrQ;
  logic lockQ;

  gateCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .pgmEn(pgmEn), .regSel(regSel), .weQ(weQ), .armQ(armQ),
    .clrQ(clrQ), .lockQ(lockQ), .bound(protValue), .stb(stb)
  );

  gateRegs #(.ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr),
    .weQ(weQ), .armQ(armQ), .clrQ(clrQ), .lockQ(lockQ), .bound(protValue),
    .commitValid(commitValid), .commitKind(commitKind),
    .commitAddr(commitAddr), .readGrant(readGrant)
  );
endmodule

// File: rtl/protGateChk.sv
module protGateChk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              pgmEn,
  input logic              regSel,
  input logic              commitValid,
  input logic [2:0]        commitKind,
  input logic [ADDR_W-1:0] protValue,
  input logic              lockQ
);
  AST_COMMIT_FROM_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> $past(cmdValid)); // R12
  AST_WORD_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && commitKind == 3'd0) |-> ($past(pgmEn) && !$past(regSel))); // R4
  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && commitKind == 3'd0) |->
      (($past(cmdAddr) < $past(protValue)) || ((&$past(protValue)) && (&$past(cmdAddr))))); // R5
  AST_FILL_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && commitKind == 3'd1) |-> (&$past(protValue))); // R6
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(protValue)); // R10
  AST_BOUND_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(protValue)); // R11
endmodule

bind protGate protGateChk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
  .pgmEn(pgmEn), .regSel(regSel), .commitValid(commitValid),
  .commitKind(commitKind), .protValue(protValue), .lockQ(lockQ)
);

// File: tb/sim_protGate.sv
`timescale 1ns/1ps
module sim_protGate;
  localparam logic [3:0] RD = 4'd0, WEN = 4'd1, WDS = 4'd2, WRD = 4'd3, FIL = 4'd4,
                         BRD = 4'd5, ARM = 4'd6, BCL = 4'd7, BST = 4'd8, BLK = 4'd9;

  typedef struct {
    logic       acc;
    logic       rd;
    logic [2:0] kind;
    logic [7:0] addr;
    string      tag;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [3:0] cmdOp = '0;
  logic [7:0] cmdAddr = '0;
  logic pgmEn = 1'b0;
  logic regSel = 1'b0;
  logic commitValid;
  logic [2:0] commitKind;
  logic [7:0] commitAddr;
  logic readGrant;
  logic [7:0] protValue;

  int tests = 0;
  int fails = 0;
  expT expQ[$];
  expT cur;

  always #5 clk = ~clk;

  protGate u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .pgmEn(pgmEn), .regSel(regSel), .commitValid(commitValid), .commitKind(commitKind),
    .commitAddr(commitAddr), .readGrant(readGrant), .protValue(protValue)
  );

  task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic pe,
                       input logic rs, input logic acc, input logic [2:0] kind,
                       input logic rd, input string tag);
    expT e;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; pgmEn = pe; regSel = rs;
    @(posedge clk);
    #1;
    e.acc = acc; e.rd = rd; e.kind = kind; e.addr = a; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic checkProt(input logic [7:0] exp, input string tag);
    tests++;
    if (protValue !== exp) begin
      fails++;
      $display("FAIL %s protValue actual=%h expected=%h", tag, protValue, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (expQ.size() > 0) begin
        cur = expQ.pop_front();
        tests++;
        if (commitValid !== cur.acc || readGrant !== cur.rd ||
            (cur.acc && (commitKind !== cur.kind || commitAddr !== cur.addr))) begin
          fails++;
          $display("FAIL %s actual v=%b rd=%b k=%0d a=%h expected v=%b rd=%b k=%0d a=%h",
                   cur.tag, commitValid, readGrant, commitKind, commitAddr,
                   cur.acc, cur.rd, cur.kind, cur.addr);
        end
      end else if (commitValid || readGrant) begin
        tests++;
        fails++;
        $display("FAIL R12 output without frame actual v=%b rd=%b expected 0 0",
                 commitValid, readGrant);
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    tests++;
    if (commitValid !== 1'b0 || readGrant !== 1'b0) begin
      fails++;
      $display("FAIL R1 outputs actual=%b%b expected=00", commitValid, readGrant);
    end
    checkProt(8'hFF, "R1");
    // R2 / R4: latch clear after reset blocks word write
    issue(WRD, 8'h10, 1, 0, 0, 0, 0, "R2 write before enable");
    issue(RD,  8'h00, 0, 0, 0, 0, 1, "R3 read while disabled");
    issue(BRD, 8'h00, 0, 1, 0, 0, 1, "R3 boundary read");
    issue(WEN, 8'hC0, 0, 0, 0, 0, 0, "R2 enable");
    issue(WRD, 8'h10, 1, 0, 1, 0, 0, "R4 word write");
    issue(WRD, 8'hFF, 1, 0, 1, 0, 0, "R5 top address at ones");
    issue(WRD, 8'h11, 0, 0, 0, 0, 0, "R4 pgmEn low");
    issue(WRD, 8'h11, 1, 1, 0, 0, 0, "R4 regSel high");
    issue(FIL, 8'h40, 1, 0, 1, 1, 0, "R6 fill at ones");
    issue(BST, 8'h40, 1, 1, 0, 0, 0, "R8 set without arm");
    checkProt(8'hFF, "R11");
    issue(ARM, 8'hC0, 1, 1, 0, 0, 0, "R7 arm");
    issue(BST, 8'h40, 1, 1, 1, 3, 0, "R9 boundary set");
    checkProt(8'h40, "R9");
    issue(WRD, 8'h3F, 1, 0, 1, 0, 0, "R5 one below boundary");
    issue(WRD, 8'h40, 1, 0, 0, 0, 0, "R5 at boundary");
    issue(WRD, 8'hFF, 1, 0, 0, 0, 0, "R5 top address not ones");
    issue(FIL, 8'h40, 1, 0, 0, 0, 0, "R6 fill not cleared");
    issue(ARM, 8'hC0, 1, 1, 0, 0, 0, "R7 arm");
    issue(BST, 8'h20, 1, 1, 0, 0, 0, "R9 set without clear");
    checkProt(8'h40, "R9");
    issue(ARM, 8'hC0, 1, 1, 0, 0, 0, "R7 arm");
    issue(RD,  8'h00, 0, 0, 0, 0, 1, "R3 read between");
    issue(BCL, 8'hFF, 1, 1, 0, 0, 0, "R8 clear after intervening read");
    checkProt(8'h40, "R8");
    issue(ARM, 8'hC0, 1, 1, 0, 0, 0, "R7 arm");
    issue(BCL, 8'hFF, 1, 1, 1, 2, 0, "R9 boundary clear");
    checkProt(8'hFF, "R9");
    issue(WDS, 8'h00, 0, 0, 0, 0, 0, "R2 disable");
    issue(WRD, 8'h05, 1, 0, 0, 0, 0, "R2 write after disable");
    issue(ARM, 8'hC0, 1, 1, 0, 0, 0, "R7 arm while disabled");
    issue(BST, 8'h10, 1, 1, 0, 0, 0, "R7 set after rejected arm");
    issue(WEN, 8'hC0, 0, 0, 0, 0, 0, "R2 enable");
    issue(ARM, 8'hC0, 0, 1, 0, 0, 0, "R7 arm pgmEn low");
    issue(BST, 8'h10, 1, 1, 0, 0, 0, "R7 set after rejected arm");
    checkProt(8'hFF, "R11");
    issue(ARM, 8'hC0, 1, 1, 0, 0, 0, "R7 arm");
    issue(BST, 8'h80, 1, 1, 1, 3, 0, "R9 boundary set");
    issue(ARM, 8'hC0, 1, 1, 0, 0, 0, "R7 arm");
    issue(BLK, 8'h00, 1, 1, 1, 4, 0, "R10 lock");
    issue(ARM, 8'hC0, 1, 1, 0, 0, 0, "R7 arm");
    issue(BCL, 8'hFF, 1, 1, 0, 0, 0, "R10 clear after lock");
    checkProt(8'h80, "R10");
    issue(ARM, 8'hC0, 1, 1, 0, 0, 0, "R7 arm");
    issue(BLK, 8'h00, 1, 1, 0, 0, 0, "R10 second lock");
    issue(WRD, 8'h7F, 1, 0, 1, 0, 0, "R5 below locked boundary");
    issue(WRD, 8'h80, 1, 0, 0, 0, 0, "R5 at locked boundary");
    checkProt(8'h80, "R10");
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule